// File: doc/BRIEF.md
# Clustered VLIW Fetch Splitter

This block sits between instruction fetch and the execution clusters of a four-cluster, eight-issue VLIW core. Each cycle it may take one wide instruction word, holding eight operations, through a valid/ready handshake. It breaks the word into four packets of two operations each and hands one packet to each cluster in the same cycle the word is accepted. The path from input to packets has no storage, so a word moves through in zero cycles.

The block also runs cluster power control. The first operation of every word is checked for a cluster-shutoff opcode. When one is present, its immediate holds one disable bit per cluster. That vector is stored in a sticky mask, which drives one clock-enable output per cluster. The new mask already governs the word that carries it, and the shutoff slot is handed to cluster 0 as a NOP. A shutoff opcode in any later slot is an ordinary operation. An override pin vetoes the mask and turns every cluster on, without erasing what the mask holds.

Back-pressure rules: the word is accepted only in a cycle where every enabled cluster is ready. The ready lines of disabled clusters are ignored. `mop_ready` follows the enables of the word being offered. The per-cluster valids rise only in the cycle of acceptance, so all enabled clusters see the word together. A word held without acceptance changes no state.

Top module: `vliw_fetch_splitter`

## Requirements
- R1: Operation slot k sits at `mop_data[32k +: 32]`. Cluster c receives slots 2c (bits 31:0 of its packet) and 2c+1 (bits 63:32) on `cl_pkt[64c +: 64]`.
- R2: `mop_ready` is high exactly when every cluster whose `cl_en` bit is high has its `cl_ready` bit high. `cl_valid[c]` is high only when `mop_valid` and `mop_ready` are both high and `cl_en[c]` is high.
- R3: A slot-0 operation whose opcode field (bits 29:24) equals 0x2F is a shutoff. When its word is accepted, immediate bits 3:0 become the mask, where bit c high disables cluster c. The mask already applies to that same word. A shutoff word that is not accepted leaves the mask unchanged.
- R4: The shutoff opcode in any slot other than 0 is forwarded unchanged and leaves the mask alone.
- R5: The shutoff slot is sent to cluster 0 as a NOP: all bits zero except the tail bit (bit 31), which is kept.
- R6: The mask persists across words that carry no shutoff.
- R7: A shutoff with an all-zero immediate enables all clusters.
- R8: After reset the mask is zero, all four `cl_en` bits are high, and no `cl_valid` bit is high while `mop_valid` is low.
- R9: While `override_on` is high, all `cl_en` bits are high and every cluster takes part in the handshake. A shutoff accepted during override still loads the mask, and the mask takes effect once override falls.
- R10: A disabled cluster has `cl_valid` low and `cl_pkt` all zero.
- R11: The reserved bit (bit 30) and the tail bit play no part in shutoff detection. Ordinary operations are forwarded with those bits intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mop_valid | input | 1 | Instruction word offered |
| mop_ready | output | 1 | Word accepted this cycle when valid |
| mop_data | input | 256 | Eight 32-bit operations, slot 0 lowest |
| override_on | input | 1 | Forces every cluster on |
| cl_ready | input | 4 | Per-cluster ready |
| cl_valid | output | 4 | Per-cluster packet valid |
| cl_pkt | output | 256 | Four 64-bit two-operation packets |
| cl_en | output | 4 | Per-cluster clock enable |

## Verification
The only state in the block is the mask. A corrupted mask shows up on `cl_en` in the first cycle after the faulty update. It then shows on `cl_valid` and on zeroed packets as soon as the next word arrives, and it changes which `cl_ready` lines can stall `mop_ready`. Wrong slot routing or a missed NOP substitution appears on `cl_pkt` in the same cycle the word is offered. Because of that, every directed scenario checks packets, enables and ready in the offering cycle, and then checks the enables again after the next edge.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  localparam int OP_W        = 32;
  localparam int TAIL_BIT    = 31;
  localparam int RSV_BIT     = 30;
  localparam int OPC_HI      = 29;
  localparam int OPC_LO      = 24;
  localparam int OPC_W       = OPC_HI - OPC_LO + 1;
  localparam logic [OPC_W-1:0] SHUTOFF_OPC = 6'h2F;

  typedef logic [OP_W-1:0] op_t;

  function automatic logic op_is_shutoff(input op_t op);
    return op[OPC_HI:OPC_LO] == SHUTOFF_OPC;
  endfunction

  function automatic op_t nop_keep_tail(input logic tail);
    op_t n;
    n = '0;
    n[TAIL_BIT] = tail;
    return n;
  endfunction
endpackage

// File: rtl/vfs_lead_decode.sv
module vfs_lead_decode
  import vfs_pkg::*;
#(
  parameter int NUM_CL = 4
) (
  input  logic              lead_valid,
  input  op_t               lead_op,
  output logic              shut_hit,
  output logic [NUM_CL-1:0] shut_imm,
  output op_t               lead_clean
);
  logic is_shut;

  // detection looks at the opcode field only; tail and reserved bits are don't-care
  always_comb begin
    is_shut    = op_is_shutoff(lead_op);
    shut_hit   = lead_valid && is_shut;
    shut_imm   = lead_op[NUM_CL-1:0];
    lead_clean = is_shut ? nop_keep_tail(lead_op[TAIL_BIT]) : lead_op;
  end
endmodule

// File: rtl/vfs_mask_ctrl.sv
module vfs_mask_ctrl #(
  parameter int NUM_CL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shut_hit,
  input  logic [NUM_CL-1:0] shut_imm,
  input  logic              accept,
  input  logic              override_on,
  output logic [NUM_CL-1:0] cl_en
);
  logic [NUM_CL-1:0] mask_q;
  logic [NUM_CL-1:0] mask_eff;

  // the offered word already sees its own shutoff vector
  always_comb begin
    mask_eff = shut_hit ? shut_imm : mask_q;
    cl_en    = override_on ? {NUM_CL{1'b1}} : ~mask_eff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  mask_q <= '0;
    else if (accept && shut_hit) mask_q <= shut_imm;
  end
endmodule

// File: rtl/vfs_lane_route.sv
module vfs_lane_route
  import vfs_pkg::*;
#(
  parameter int NUM_CL     = 4,
  parameter int OPS_PER_CL = 2,
  localparam int PKT_W     = OPS_PER_CL * OP_W,
  localparam int MOP_W     = NUM_CL * PKT_W
) (
  input  logic [MOP_W-1:0]        mop_data,
  input  op_t                     lead_clean,
  input  logic [NUM_CL-1:0]       cl_en,
  input  logic                    fire,
  output logic [NUM_CL-1:0]       cl_valid,
  output logic [NUM_CL*PKT_W-1:0] cl_pkt
);
  for (genvar c = 0; c < NUM_CL; c++) begin : g_cl
    logic [PKT_W-1:0] pkt;
    for (genvar k = 0; k < OPS_PER_CL; k++) begin : g_slot
      localparam int IDX = c * OPS_PER_CL + k;
      if (IDX == 0) begin : g_lead
        assign pkt[k*OP_W +: OP_W] = lead_clean;
      end else begin : g_plain
        assign pkt[k*OP_W +: OP_W] = mop_data[IDX*OP_W +: OP_W];
      end
    end
    assign cl_pkt[c*PKT_W +: PKT_W] = cl_en[c] ? pkt : '0;
    assign cl_valid[c]              = fire && cl_en[c];
  end
endmodule

// File: rtl/vliw_fetch_splitter.sv
module vliw_fetch_splitter
  import vfs_pkg::*;
#(
  parameter int NUM_CL     = 4,
  parameter int OPS_PER_CL = 2,
  localparam int PKT_W     = OPS_PER_CL * OP_W,
  localparam int MOP_W     = NUM_CL * PKT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mop_valid,
  output logic                    mop_ready,
  input  logic [MOP_W-1:0]        mop_data,
  input  logic                    override_on,
  input  logic [NUM_CL-1:0]       cl_ready,
  output logic [NUM_CL-1:0]       cl_valid,
  output logic [NUM_CL*PKT_W-1:0] cl_pkt,
  output logic [NUM_CL-1:0]       cl_en
);
  logic              shut_hit;
  logic [NUM_CL-1:0] shut_imm;
  op_t               lead_clean;
  logic              fire;

  vfs_lead_decode #(.NUM_CL(NUM_CL)) u_lead (
    .lead_valid (mop_valid),
    .lead_op    (mop_data[OP_W-1:0]),
    .shut_hit   (shut_hit),
    .shut_imm   (shut_imm),
    .lead_clean (lead_clean)
  );

  vfs_mask_ctrl #(.NUM_CL(NUM_CL)) u_mask (
    .clk         (clk),
    .rst_n       (rst_n),
    .shut_hit    (shut_hit),
    .shut_imm    (shut_imm),
    .accept      (fire),
    .override_on (override_on),
    .cl_en       (cl_en)
  );

  // disabled clusters cannot stall the word
  assign mop_ready = &(cl_ready | ~cl_en);
  assign fire      = mop_valid && mop_ready;

  vfs_lane_route #(.NUM_CL(NUM_CL), .OPS_PER_CL(OPS_PER_CL)) u_route (
    .mop_data   (mop_data),
    .lead_clean (lead_clean),
    .cl_en      (cl_en),
    .fire       (fire),
    .cl_valid   (cl_valid),
    .cl_pkt     (cl_pkt)
  );
endmodule

// File: rtl/vliw_fetch_splitter_chk.sv
module vliw_fetch_splitter_chk #(
  parameter int NUM_CL = 4,
  parameter int PKT_W  = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    mop_valid,
  input logic                    mop_ready,
  input logic [5:0]              lead_opc,
  input logic [30:0]             lead_low,
  input logic                    override_on,
  input logic [NUM_CL-1:0]       cl_ready,
  input logic [NUM_CL-1:0]       cl_valid,
  input logic [NUM_CL*PKT_W-1:0] cl_pkt,
  input logic [NUM_CL-1:0]       cl_en
);
  logic lead_shut;
  logic off_pkt_nonzero;
  assign lead_shut = (lead_opc == 6'h2F);

  always_comb begin
    off_pkt_nonzero = 1'b0;
    for (int c = 0; c < NUM_CL; c++)
      if (!cl_en[c] && (cl_pkt[c*PKT_W +: PKT_W] != '0)) off_pkt_nonzero = 1'b1;
  end

  assert_valid_only_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_valid & ~cl_en) == '0);

  assert_off_pkt_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !off_pkt_nonzero);

  assert_override_all_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    override_on |-> (&cl_en));

  assert_accept_needs_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mop_valid && mop_ready) |-> (&(cl_ready | ~cl_en)));

  assert_lockstep_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_valid != '0) |-> (mop_valid && mop_ready));

  assert_lead_nop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_valid[0] && lead_shut) |-> (lead_low == '0));

  assert_mask_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!override_on && !(mop_valid && lead_shut)) |=>
      ((mop_valid && lead_shut) || override_on || (cl_en == $past(cl_en))));
endmodule

bind vliw_fetch_splitter vliw_fetch_splitter_chk #(.NUM_CL(NUM_CL), .PKT_W(PKT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mop_valid   (mop_valid),
  .mop_ready   (mop_ready),
  .lead_opc    (mop_data[29:24]),
  .lead_low    (cl_pkt[30:0]),
  .override_on (override_on),
  .cl_ready    (cl_ready),
  .cl_valid    (cl_valid),
  .cl_pkt      (cl_pkt),
  .cl_en       (cl_en)
);

// File: tb/vliw_fetch_splitter_tb.sv
module vliw_fetch_splitter_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mop_valid = 1'b0;
  logic         mop_ready;
  logic [255:0] mop_data = '0;
  logic         override_on = 1'b0;
  logic [3:0]   cl_ready = 4'hF;
  logic [3:0]   cl_valid;
  logic [255:0] cl_pkt;
  logic [3:0]   cl_en;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] ops [8];

  always #5 clk = ~clk;

  vliw_fetch_splitter u_dut (
    .clk(clk), .rst_n(rst_n), .mop_valid(mop_valid), .mop_ready(mop_ready),
    .mop_data(mop_data), .override_on(override_on), .cl_ready(cl_ready),
    .cl_valid(cl_valid), .cl_pkt(cl_pkt), .cl_en(cl_en)
  );

  function automatic logic [31:0] mk_op(logic tail, logic rsv, logic [5:0] opc, logic [23:0] pay);
    return {tail, rsv, opc, pay};
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic plain_ops(logic [7:0] seed);
    for (int k = 0; k < 8; k++)
      ops[k] = mk_op(k == 7, k[0], 6'h01 + 6'(k), {seed, 8'(k), 8'hA5 ^ 8'(k)});
  endtask

  task automatic load_mop();
    for (int k = 0; k < 8; k++) mop_data[k*32 +: 32] = ops[k];
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    mop_valid = 1'b0;
    #2;
    chk("R8 enables after reset", 64'(cl_en), 64'hF);
    chk("R8 no valid when idle", 64'(cl_valid), 64'h0);
  endtask

  task automatic t_split();
    step();
    plain_ops(8'h11); load_mop(); cl_ready = 4'hF; mop_valid = 1'b1;
    #2;
    chk("R2 ready all on", 64'(mop_ready), 64'h1);
    chk("R2 valids", 64'(cl_valid), 64'hF);
    for (int c = 0; c < 4; c++)
      chk("R1 packet mapping", cl_pkt[c*64 +: 64], {ops[2*c+1], ops[2*c]});
    step();
    plain_ops(8'h22); ops[3][30] = 1'b1; load_mop();
    #2;
    chk("R11 reserved bit forwarded", cl_pkt[64 +: 64], {ops[3], ops[2]});
  endtask

  task automatic t_backpressure();
    step();
    cl_ready = 4'b1011;
    #2;
    chk("R2 stall on not-ready enabled cluster", 64'(mop_ready), 64'h0);
    chk("R2 no valids while stalled", 64'(cl_valid), 64'h0);
    cl_ready = 4'hF;
  endtask

  task automatic t_shutoff();
    step();
    plain_ops(8'h33);
    ops[0] = mk_op(1'b0, 1'b1, 6'h2F, 24'h000006);   // reserved bit set, imm 0110
    load_mop(); cl_ready = 4'b1001; mop_valid = 1'b1;
    #2;
    chk("R3 same-word enables", 64'(cl_en), 64'h9);
    chk("R2 disabled ready ignored", 64'(mop_ready), 64'h1);
    chk("R10 valids only enabled", 64'(cl_valid), 64'h9);
    chk("R10 cluster1 packet zero", cl_pkt[64 +: 64], 64'h0);
    chk("R10 cluster2 packet zero", cl_pkt[128 +: 64], 64'h0);
    chk("R5 lead slot as NOP", cl_pkt[0 +: 64], {ops[1], 32'h0});
    step();
    plain_ops(8'h44); load_mop();
    #2;
    chk("R6 mask persists", 64'(cl_en), 64'h9);
    chk("R6 valids persist", 64'(cl_valid), 64'h9);
    chk("R1 cluster3 packet", cl_pkt[192 +: 64], {ops[7], ops[6]});
    cl_ready = 4'hF;
  endtask

  task automatic t_not_lead();
    step();
    plain_ops(8'h55);
    ops[6] = mk_op(1'b0, 1'b0, 6'h2F, 24'h00000F);
    load_mop();
    #2;
    chk("R4 later shutoff forwarded", cl_pkt[192 +: 64], {ops[7], ops[6]});
    chk("R4 enables same word", 64'(cl_en), 64'h9);
    step();
    mop_valid = 1'b0;
    #2;
    chk("R4 mask unchanged", 64'(cl_en), 64'h9);
  endtask

  task automatic t_override();
    step();
    plain_ops(8'h66); load_mop(); override_on = 1'b1; mop_valid = 1'b1;
    #2;
    chk("R9 override enables", 64'(cl_en), 64'hF);
    chk("R9 override valids", 64'(cl_valid), 64'hF);
    step();
    ops[0] = mk_op(1'b0, 1'b0, 6'h2F, 24'h000001); load_mop();
    #2;
    chk("R9 override beats new mask", 64'(cl_en), 64'hF);
    chk("R5 NOP under override", cl_pkt[0 +: 64], {ops[1], 32'h0});
    step();
    mop_valid = 1'b0; override_on = 1'b0;
    #2;
    chk("R9 mask loaded during override", 64'(cl_en), 64'hE);
    chk("R3 bit0 maps to cluster0", 64'(cl_en[0]), 64'h0);
  endtask

  task automatic t_stall_keeps_mask();
    step();
    plain_ops(8'h77);
    ops[0] = mk_op(1'b1, 1'b0, 6'h2F, 24'h000008);   // tail set, imm 1000
    load_mop(); cl_ready = 4'h0; mop_valid = 1'b1;
    #2;
    chk("R11 tail ignored in detection", 64'(cl_en), 64'h7);
    chk("R2 stalled shutoff", 64'(mop_ready), 64'h0);
    chk("R5 tail kept on NOP", cl_pkt[0 +: 32], 64'h8000_0000);
    step();
    mop_valid = 1'b0; cl_ready = 4'hF;
    #2;
    chk("R3 unaccepted shutoff no update", 64'(cl_en), 64'hE);
  endtask

  task automatic t_zero_imm();
    step();
    plain_ops(8'h88);
    ops[0] = mk_op(1'b0, 1'b0, 6'h2F, 24'h000000);
    load_mop(); mop_valid = 1'b1;
    #2;
    chk("R7 zero imm all on", 64'(cl_en), 64'hF);
    chk("R7 all valid", 64'(cl_valid), 64'hF);
    step();
    mop_valid = 1'b0;
    #2;
    chk("R7 all on persists", 64'(cl_en), 64'hF);
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_split();
    t_backpressure();
    t_shutoff();
    t_not_lead();
    t_override();
    t_stall_keeps_mask();
    t_zero_imm();
    step();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule